// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block sits in a digital-to-analog converter's sample path and fades a stereo stream of 20-bit two's complement samples in and out. A mute request moves a shared gain one step per sample frame. While the request is high, the gain walks down from unity to silence. While it is low, the gain walks back up to unity. One frame strobe marks each sample frame, so the length of a fade is set in frames and not in clock cycles.

The gain is a counter from 0 to 1024. Each output sample is the input sample times the gain, shifted right arithmetically by ten bits. Both channels use the same gain in every frame, so the stereo balance is kept. If the request changes while a fade is still running, the counter turns around from the value it has reached. It does not jump or restart. A status flag reports when the gain has reached zero.

Top module: `softmute_ramp`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the gain to unity (1024), clears both outputs to zero and drives `muted` low.
- R2: On a clock edge with `frame_stb` high, each output is loaded with floor(input × g / 1024), using an arithmetic right shift, where g is the gain held before that edge. The outputs keep their value on edges without a strobe.
- R3: While `mute_req` is high, each frame strobe lowers the gain by one. Starting from unity, the gain reaches zero on the 1024th strobe and not before.
- R4: While `mute_req` is low, each frame strobe raises the gain by one until it reaches 1024. From then on the outputs equal the inputs.
- R5: While `mute_req` stays high, the gain holds at zero once it gets there, and the outputs stay zero.
- R6: A change of `mute_req` during a fade reverses the direction from the present gain. It causes no jump and no restart.
- R7: The left and right outputs of one frame are scaled by the same gain.
- R8: `muted` is high exactly while the gain is zero. It changes on the same edge as the gain.
- R9: Changes of `mute_req` or of the sample inputs on edges without a strobe change neither the outputs nor the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | High requests a fade to silence; low requests a fade to unity |
| frame_stb | input | 1 | One-cycle pulse per sample frame |
| left_in | input | 20 | Left sample, two's complement |
| right_in | input | 20 | Right sample, two's complement |
| left_out | output | 20 | Scaled left sample, registered |
| right_out | output | 20 | Scaled right sample, registered |
| muted | output | 1 | High while the gain is zero |

## Verification
A gain step and the scaling of a sample happen on the same strobe edge. A change of the mute request can also fall on that edge. The bench checks that the scaling uses the gain from before the step. It turns the request around on the very frame after a partial fade, then follows the gain back frame by frame through the outputs. Each frame's outputs are compared with a bench gain model that applies the step only after computing the expected product. An off-by-one in the ordering, or a reset of the gain on reversal, therefore shows up as a product mismatch.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  localparam int SM_DATA_W    = 20;
  localparam int SM_RAMP_LOG2 = 10;
  localparam int SM_NUM_CH    = 2;
endpackage

// File: rtl/softmute_gain_ctr.sv
module softmute_gain_ctr #(
  parameter int RAMP_LOG2 = 10,
  localparam int GW = RAMP_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          go_down,
  output logic [GW-1:0] gain,
  output logic          at_zero
);
  localparam logic [GW-1:0] FULL = {1'b1, {RAMP_LOG2{1'b0}}};

  logic [GW-1:0] gain_nxt;

  always_comb begin
    gain_nxt = gain;
    if (step_en) begin
      if (go_down) begin
        if (gain != '0) gain_nxt = gain - 1'b1;
      end else begin
        if (gain != FULL) gain_nxt = gain + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain    <= FULL;
      at_zero <= 1'b0;
    end else begin
      gain    <= gain_nxt;
      at_zero <= (gain_nxt == '0);
    end
  end

  p_range_r3: assert property (@(posedge clk) disable iff (rst) gain <= FULL);
  p_down_r3: assert property (@(posedge clk) disable iff (rst)
    step_en && go_down && gain != '0 |=> gain == $past(gain) - 1'b1);
  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    step_en && !go_down && gain != FULL |=> gain == $past(gain) + 1'b1);
  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    step_en && go_down && gain == '0 |=> gain == '0);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(gain));
  p_flag_r8: assert property (@(posedge clk) disable iff (rst)
    at_zero == (gain == '0));
endmodule

// File: rtl/softmute_scaler.sv
module softmute_scaler #(
  parameter int DATA_W    = 20,
  parameter int RAMP_LOG2 = 10,
  localparam int GW = RAMP_LOG2 + 1,
  localparam int PW = DATA_W + GW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [GW-1:0]            gain,
  output logic signed [DATA_W-1:0] scaled
);
  localparam logic [GW-1:0] FULL = {1'b1, {RAMP_LOG2{1'b0}}};

  logic signed [PW-1:0] s_ext;
  logic signed [PW-1:0] g_ext;
  logic signed [PW-1:0] prod;

  always_comb begin
    s_ext = PW'(sample);
    g_ext = $signed(PW'(gain));
    prod  = s_ext * g_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)       scaled <= '0;
    else if (load) scaled <= DATA_W'(prod >>> RAMP_LOG2);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(scaled));
  p_unity_r4: assert property (@(posedge clk) disable iff (rst)
    load && gain == FULL |=> scaled == $past(sample));
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    load && gain == '0 |=> scaled == '0);
endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
  import softmute_pkg::*;
#(
  parameter int DATA_W    = SM_DATA_W,
  parameter int RAMP_LOG2 = SM_RAMP_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_req,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              muted
);
  localparam int GW = RAMP_LOG2 + 1;

  logic [GW-1:0]            gain;
  logic signed [DATA_W-1:0] ch_in  [SM_NUM_CH];
  logic signed [DATA_W-1:0] ch_out [SM_NUM_CH];

  assign ch_in[0]  = $signed(left_in);
  assign ch_in[1]  = $signed(right_in);
  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  softmute_gain_ctr #(.RAMP_LOG2(RAMP_LOG2)) u_gain (
    .clk     (clk),
    .rst     (rst),
    .step_en (frame_stb),
    .go_down (mute_req),
    .gain    (gain),
    .at_zero (muted)
  );

  // One scaler per channel, all fed from the same gain register (R7)
  for (genvar ch = 0; ch < SM_NUM_CH; ch++) begin : g_ch
    softmute_scaler #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scl (
      .clk    (clk),
      .rst    (rst),
      .load   (frame_stb),
      .sample (ch_in[ch]),
      .gain   (gain),
      .scaled (ch_out[ch])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (left_out == '0 && right_out == '0 && !muted));
  p_silent_r7: assert property (@(posedge clk) disable iff (rst)
    muted && $past(muted) && $past(frame_stb) |-> (left_out == '0 && right_out == '0));
endmodule

// File: tb/sim_softmute_ramp.sv
module sim_softmute_ramp;
  localparam int DW = 20;

  logic clk = 0, rst = 1, mute_req = 0, frame_stb = 0;
  logic [DW-1:0] left_in = '0, right_in = '0;
  logic [DW-1:0] left_out, right_out;
  logic muted;

  int n_chk = 0, n_fail = 0;
  int g_model = 1024;

  always #5 clk = ~clk;

  softmute_ramp u0 (
    .clk(clk), .rst(rst), .mute_req(mute_req), .frame_stb(frame_stb),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .muted(muted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int pat(input int k, input int salt);
    int v = ((k * 7919 + salt * 104729) % 1048576) - 524288;
    if (k % 17 == 0) v = 524287;
    if (k % 19 == 0) v = -524288;
    if (k % 23 == 0) v = -1;
    return v;
  endfunction

  // one frame: drive, strobe, compare with model (gain before step), then step model
  task automatic frame(input int l, input int r, input string req);
    int el, er;
    @(negedge clk);
    left_in = DW'(l); right_in = DW'(r); frame_stb = 1;
    @(posedge clk);
    @(negedge clk);
    frame_stb = 0;
    el = (l * g_model) >>> 10;
    er = (r * g_model) >>> 10;
    if (mute_req) begin if (g_model > 0) g_model--; end
    else begin if (g_model < 1024) g_model++; end
    chk({req, " left"},  sx(left_out),  el);
    chk({req, " right R7"}, sx(right_out), er);
    chk({req, " muted R8"}, int'(muted), int'(g_model == 0));
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    g_model = 1024;
    chk("R1 left zero", sx(left_out), 0);
    chk("R1 right zero", sx(right_out), 0);
    chk("R1 muted low", int'(muted), 0);
    frame(123456, -98765, "R1 unity after reset");
  endtask

  task automatic t_fade_down;
    mute_req = 1;
    for (int k = 1; k <= 1024; k++) begin
      frame(pat(k, 1), pat(k, 2), "R3 fade down");
      if (k == 1023) chk("R3 not muted at 1023", int'(muted), 0);
    end
    chk("R3 muted after 1024", int'(muted), 1);
  endtask

  task automatic t_floor;
    for (int k = 0; k < 8; k++) frame(524287, -524288, "R5 floor");
    chk("R5 left silent", sx(left_out), 0);
    chk("R5 right silent", sx(right_out), 0);
  endtask

  task automatic t_fade_up;
    mute_req = 0;
    for (int k = 1; k <= 1030; k++) frame(pat(k, 3), pat(k, 4), "R4 fade up");
    frame(-300001, 299999, "R4 unity");
    chk("R4 passthrough", sx(left_out), -300001);
  endtask

  task automatic t_reverse;
    mute_req = 1;
    for (int k = 1; k <= 300; k++) frame(pat(k, 5), pat(k, 6), "R6 partial down");
    chk("R6 gain reached", g_model, 724);
    mute_req = 0;
    for (int k = 1; k <= 150; k++) frame(pat(k, 7), pat(k, 8), "R6 reversed up");
    mute_req = 1;
    for (int k = 1; k <= 40; k++) frame(pat(k, 9), pat(k, 10), "R6 reversed down");
    mute_req = 0;
    for (int k = 1; k <= 200; k++) frame(pat(k, 11), pat(k, 12), "R6 back to unity");
  endtask

  task automatic t_idle;
    logic [DW-1:0] hl, hr;
    logic hm;
    mute_req = 1;
    frame(400000, -400000, "R9 setup");
    hl = left_out; hr = right_out; hm = muted;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      mute_req = k[0]; left_in = DW'(pat(k, 13)); right_in = DW'(pat(k, 14));
    end
    @(negedge clk);
    chk("R9 left held", sx(left_out), sx(hl));
    chk("R9 right held", sx(right_out), sx(hr));
    chk("R9 muted held", int'(muted), int'(hm));
    mute_req = 0;
    frame(250000, -250001, "R9 gain unchanged");
    frame(-7, 7, "R2 small values");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_fade_down;
    t_floor;
    t_fade_up;
    t_reverse;
    t_idle;
    mute_req = 1;
    for (int k = 1; k <= 50; k++) frame(pat(k, 15), pat(k, 16), "R1 mid-fade");
    t_reset;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule